// File: doc/BRIEF.md
# Card Readout Framer

This block turns one card's event snapshot into a fixed-length stream of 16-bit words. A capture strobe freezes the event number, two 17-bit I/O vectors and the words offered by sixteen data sources (two words each). A later transport strobe plays the frozen snapshot out as exactly 40 words on consecutive clock cycles. The stream opens with two header words, carries the source words in source order, adds four words for the I/O vectors, and closes with two trailer words.

The block also checks the order of the commands. A capture is expected to be followed by exactly one transport, and no command may arrive while a stream is running. Each violation raises a sticky flag that is reported in the trailer of the next readout to reach its trailer word, and is then cleared. The card identity fields and the version bytes are static configuration inputs. They are read live, while everything else in the stream comes from the captured snapshot.

Top module: `rdo_framer`

## Requirements
- R1: A transport accepted while idle makes `out_valid_o` high for exactly 40 consecutive cycles, starting in the cycle after the strobe. The words come out in index order 0 to 39, and `out_last_o` is high only with word 39.
- R2: Word 0 holds the captured event number in bits 15:8 and the card ID byte in bits 7:0. The ID byte has the master bit in bit 7, the slave position in bits 6:5 and the slot in bits 4:0.
- R3: Word 1 holds the primary version byte in bits 15:8 and the primary revision byte in bits 7:0. With `USE_ALT_VER`=1 (the default), word 38 holds the secondary version and revision in the same layout. With `USE_ALT_VER`=0, word 38 is zero.
- R4: Word 2+2*s+w is captured word w (0 or 1) of source s. On the input bus it sits at bits 16*(2*s+w)+15 down to 16*(2*s+w). The stream always shows the snapshot taken at the last accepted capture, whatever the inputs do afterwards.
- R5: Word 34 is board I/O bits 15:0 and word 36 is backplane I/O bits 15:0. Words 35 and 37 carry bit 16 of the board and backplane vectors in bit 0, with zeros in bits 15:1.
- R6: Word 39 holds the captured event number in bits 7:0. Bit 8 is 1 when the readout was started with a capture pending. Bit 9 is 1, since the word is sent during a transport. Bits 15:14 are 0.
- R7: Word 39 bits 10 to 13 are protocol flags. Bit 10 is set by a capture while idle with a capture already pending; the newer snapshot replaces the older. Bit 11 is set by a transport started with no capture pending; that readout replays the last snapshot (all zeros after reset). Bit 12 is set by a capture in any cycle with valid high; that capture is ignored. Bit 13 is set by a transport in any cycle with valid high; that transport is ignored.
- R8: A flag stays set until the cycle of word 39 of a readout whose trailer showed it, and is cleared after that cycle. A flag raised in the cycle of word 39 is kept for the next readout.
- R9: A capture and a transport in the same idle cycle act as a capture followed by a transport. The readout carries the new snapshot, and bit 11 is not set.
- R10: After reset, and whenever no readout is running, valid and last are low and the word output is zero. After reset the snapshot is zero and no flag is set.
- R11: The pending-capture state is cleared at the end of every readout. A second transport with no capture in between therefore sets bit 11 and shows bit 8 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_i | input | 1 | Capture strobe |
| xfer_i | input | 1 | Transport strobe |
| evt_num_i | input | 8 | Event number to capture |
| id_master_i | input | 1 | Card ID master bit |
| id_pos_i | input | 2 | Card ID slave position (0 to 2) |
| id_slot_i | input | 5 | Card ID slot (2 to 21) |
| ver_i | input | 8 | Primary version byte |
| rev_i | input | 8 | Primary revision byte |
| alt_ver_i | input | 8 | Secondary version byte |
| alt_rev_i | input | 8 | Secondary revision byte |
| brd_io_i | input | 17 | Board I/O vector |
| bp_io_i | input | 17 | Backplane I/O vector |
| src_words_i | input | NSRC*WPS*16 (512) | Source words, word k in bits 16k+15:16k |
| out_word_o | output | 16 | Stream word |
| out_valid_o | output | 1 | Stream word valid |
| out_last_o | output | 1 | Final word of a readout |

## Verification
A wrong word index or a stalled run counter shows at once as a word in the wrong slot, or as `out_last_o` arriving early, late or never, within the 40 cycles of that readout. Flag and pending-capture state can only be seen in trailer word 39, so a wrong sticky or clearing rule shows up one readout later, when the next trailer is compared. For that reason the stimulus injects strobes at chosen word positions, including the last word. A snapshot that is not held shows as changed data words, because the bench scrambles every data input right after each capture.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

    localparam int WORD_W    = 16;
    localparam int HDR_WORDS = 2;
    localparam int AUX_WORDS = 4;
    localparam int TRL_WORDS = 2;
    localparam int EVT_W     = 8;
    localparam int IO_W      = 17;

    typedef logic [WORD_W-1:0] word_t;

    // Packed so that the first member is the highest bit: maps to trailer bits 13..10
    typedef struct packed {
        logic xfer_in_xfer;
        logic cap_in_xfer;
        logic xfer_no_cap;
        logic cap_twice;
    } proto_err_t;

endpackage

// File: rtl/rdo_cmd_tracker.sv
module rdo_cmd_tracker
    import rdo_pkg::*;
#(
    parameter int TOTAL = 40,
    parameter int IDX_W = $clog2(TOTAL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic             xfer_i,
    output logic             latch_o,
    output logic             active_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o,
    output logic             captured_o,
    output proto_err_t       err_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

    typedef struct packed {
        logic             act;
        logic [IDX_W-1:0] idx;
        logic             cap;
        proto_err_t       err;
    } trk_t;

    trk_t       st_d, st_q;
    proto_err_t new_err;
    logic       done;
    logic       latch;

    always_comb begin
        st_d    = st_q;
        new_err = '0;
        latch   = 1'b0;
        done    = st_q.act && (st_q.idx == LAST_IDX);
        if (st_q.act) begin
            // any command while streaming is ignored and only flagged
            new_err.cap_in_xfer  = cap_i;
            new_err.xfer_in_xfer = xfer_i;
            if (done) begin
                st_d.act = 1'b0;
                st_d.idx = '0;
                st_d.cap = 1'b0;
                st_d.err = new_err;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
                st_d.err = st_q.err | new_err;
            end
        end else begin
            if (cap_i) begin
                latch             = 1'b1;
                new_err.cap_twice = st_q.cap;
                st_d.cap          = 1'b1;
            end
            if (xfer_i) begin
                st_d.act            = 1'b1;
                st_d.idx            = '0;
                new_err.xfer_no_cap = !st_q.cap && !cap_i;
            end
            st_d.err = st_q.err | new_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_o    = latch;
    assign active_o   = st_q.act;
    assign idx_o      = st_q.idx;
    assign last_o     = done;
    assign captured_o = st_q.cap;
    assign err_o      = st_q.err;

    logic [3:0] err_bits;
    assign err_bits = st_q.err;

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.act |-> (st_q.idx <= LAST_IDX)); // R1
    AST_RUN_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && !done) |=> (st_q.act && st_q.idx == $past(st_q.idx) + 1'b1)); // R1
    AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !st_q.act); // R1
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ((err_bits & $past(err_bits)) == $past(err_bits))); // R8
    AST_PENDING_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !st_q.cap); // R11
    AST_NOCAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.act && xfer_i && !cap_i && !st_q.cap) |=> st_q.err.xfer_no_cap); // R7
    AST_BUSY_CAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && !done && cap_i) |=> st_q.err.cap_in_xfer); // R7

endmodule

// File: rtl/rdo_snapshot.sv
module rdo_snapshot
    import rdo_pkg::*;
#(
    parameter int NDATA = 32,
    parameter int SRC_W = NDATA * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [EVT_W-1:0] evt_i,
    input  logic [IO_W-1:0]  brd_i,
    input  logic [IO_W-1:0]  bp_i,
    input  logic [SRC_W-1:0] src_i,
    output logic [EVT_W-1:0] evt_o,
    output logic [IO_W-1:0]  brd_o,
    output logic [IO_W-1:0]  bp_o,
    output logic [SRC_W-1:0] src_o
);

    typedef struct packed {
        logic [EVT_W-1:0] evt;
        logic [IO_W-1:0]  brd;
        logic [IO_W-1:0]  bp;
        logic [SRC_W-1:0] src;
    } snap_t;

    snap_t snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (load_i) begin
            snap_d.evt = evt_i;
            snap_d.brd = brd_i;
            snap_d.bp  = bp_i;
            snap_d.src = src_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else begin
            snap_q <= snap_d;
        end
    end

    assign evt_o = snap_q.evt;
    assign brd_o = snap_q.brd;
    assign bp_o  = snap_q.bp;
    assign src_o = snap_q.src;

endmodule

// File: rtl/rdo_word_sel.sv
module rdo_word_sel
    import rdo_pkg::*;
#(
    parameter int NDATA = 32,
    parameter int IDX_W = 6,
    parameter int SRC_W = NDATA * WORD_W
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [EVT_W-1:0] evt_i,
    input  logic [7:0]       card_id_i,
    input  word_t            ver_word_i,
    input  word_t            trl0_word_i,
    input  logic [IO_W-1:0]  brd_i,
    input  logic [IO_W-1:0]  bp_i,
    input  logic [SRC_W-1:0] src_i,
    input  logic             active_i,
    input  logic             captured_i,
    input  proto_err_t       err_i,
    output word_t            word_o
);

    localparam int DATA_BASE = HDR_WORDS;
    localparam int AUX_BASE  = DATA_BASE + NDATA;
    localparam int TRL_BASE  = AUX_BASE + AUX_WORDS;

    always_comb begin
        int unsigned pos;
        pos    = 32'(idx_i);
        word_o = '0;
        if (pos == 0) begin
            word_o = {evt_i, card_id_i};
        end else if (pos < DATA_BASE) begin
            word_o = ver_word_i;
        end else if (pos < AUX_BASE) begin
            word_o = src_i[(pos - DATA_BASE) * WORD_W +: WORD_W];
        end else if (pos < TRL_BASE) begin
            case (pos - AUX_BASE)
                0:       word_o = brd_i[WORD_W-1:0];
                1:       word_o = {{(WORD_W-1){1'b0}}, brd_i[IO_W-1]};
                2:       word_o = bp_i[WORD_W-1:0];
                default: word_o = {{(WORD_W-1){1'b0}}, bp_i[IO_W-1]};
            endcase
        end else if (pos == TRL_BASE) begin
            word_o = trl0_word_i;
        end else begin
            word_o = {2'b00, err_i, active_i, captured_i, evt_i};
        end
    end

endmodule

// File: rtl/rdo_framer.sv
module rdo_framer
    import rdo_pkg::*;
#(
    parameter int NSRC        = 16,
    parameter int WPS         = 2,
    parameter int USE_ALT_VER = 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cap_i,
    input  logic                            xfer_i,
    input  logic [7:0]                      evt_num_i,
    input  logic                            id_master_i,
    input  logic [1:0]                      id_pos_i,
    input  logic [4:0]                      id_slot_i,
    input  logic [7:0]                      ver_i,
    input  logic [7:0]                      rev_i,
    input  logic [7:0]                      alt_ver_i,
    input  logic [7:0]                      alt_rev_i,
    input  logic [16:0]                     brd_io_i,
    input  logic [16:0]                     bp_io_i,
    input  logic [NSRC*WPS*16-1:0]          src_words_i,
    output logic [15:0]                     out_word_o,
    output logic                            out_valid_o,
    output logic                            out_last_o
);

    localparam int NDATA = NSRC * WPS;
    localparam int SRC_W = NDATA * WORD_W;
    localparam int TOTAL = HDR_WORDS + NDATA + AUX_WORDS + TRL_WORDS;
    localparam int IDX_W = $clog2(TOTAL);

    logic             latch;
    logic             active;
    logic [IDX_W-1:0] idx;
    logic             last;
    logic             captured;
    proto_err_t       err;
    logic [EVT_W-1:0] evt_q;
    logic [IO_W-1:0]  brd_q, bp_q;
    logic [SRC_W-1:0] src_q;
    word_t            trl0_word;
    word_t            sel_word;

    rdo_cmd_tracker #(.TOTAL(TOTAL), .IDX_W(IDX_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_i      (cap_i),
        .xfer_i     (xfer_i),
        .latch_o    (latch),
        .active_o   (active),
        .idx_o      (idx),
        .last_o     (last),
        .captured_o (captured),
        .err_o      (err)
    );

    rdo_snapshot #(.NDATA(NDATA), .SRC_W(SRC_W)) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (latch),
        .evt_i  (evt_num_i),
        .brd_i  (brd_io_i),
        .bp_i   (bp_io_i),
        .src_i  (src_words_i),
        .evt_o  (evt_q),
        .brd_o  (brd_q),
        .bp_o   (bp_q),
        .src_o  (src_q)
    );

    generate
        if (USE_ALT_VER != 0) begin : g_alt_ver
            assign trl0_word = {alt_ver_i, alt_rev_i};
        end else begin : g_no_alt_ver
            assign trl0_word = '0;
        end
    endgenerate

    rdo_word_sel #(.NDATA(NDATA), .IDX_W(IDX_W), .SRC_W(SRC_W)) u_sel (
        .idx_i       (idx),
        .evt_i       (evt_q),
        .card_id_i   ({id_master_i, id_pos_i, id_slot_i}),
        .ver_word_i  ({ver_i, rev_i}),
        .trl0_word_i (trl0_word),
        .brd_i       (brd_q),
        .bp_i        (bp_q),
        .src_i       (src_q),
        .active_i    (active),
        .captured_i  (captured),
        .err_i       (err),
        .word_o      (sel_word)
    );

    assign out_word_o  = active ? sel_word : '0;
    assign out_valid_o = active;
    assign out_last_o  = last;

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |-> out_valid_o); // R1
    AST_SNAPSHOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_last_o) |=> ($stable(evt_q) && $stable(src_q))); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (!out_last_o && out_word_o == '0)); // R10

endmodule

// File: tb/tb_rdo_framer.sv
module tb_rdo_framer;

    localparam int NW = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cap = 1'b0, xfer = 1'b0;
    logic [7:0]   evt = '0;
    logic         id_m = 1'b0;
    logic [1:0]   id_p = '0;
    logic [4:0]   id_s = 5'd2;
    logic [7:0]   ver = '0, rev = '0, aver = '0, arev = '0;
    logic [16:0]  brd = '0, bp = '0;
    logic [511:0] src_v = '0;
    logic [15:0]  out_word;
    logic         out_valid, out_last;

    // bench model
    logic [7:0]   m_evt = '0;
    logic [16:0]  m_brd = '0, m_bp = '0;
    logic [511:0] m_src = '0;
    logic         m_cap = 1'b0;
    logic [3:0]   m_err = '0; // {xfer_in_xfer, cap_in_xfer, xfer_no_cap, cap_twice}

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rdo_framer dut (
        .clk(clk), .rst_n(rst_n), .cap_i(cap), .xfer_i(xfer), .evt_num_i(evt),
        .id_master_i(id_m), .id_pos_i(id_p), .id_slot_i(id_s),
        .ver_i(ver), .rev_i(rev), .alt_ver_i(aver), .alt_rev_i(arev),
        .brd_io_i(brd), .bp_io_i(bp), .src_words_i(src_v),
        .out_word_o(out_word), .out_valid_o(out_valid), .out_last_o(out_last)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input int i, input logic cap_at_start);
        if (i == 0)       return {m_evt, id_m, id_p, id_s};
        else if (i == 1)  return {ver, rev};
        else if (i < 34)  return m_src[(i-2)*16 +: 16];
        else if (i == 34) return m_brd[15:0];
        else if (i == 35) return {15'd0, m_brd[16]};
        else if (i == 36) return m_bp[15:0];
        else if (i == 37) return {15'd0, m_bp[16]};
        else if (i == 38) return {aver, arev};
        else              return {2'b00, m_err, 1'b1, cap_at_start, m_evt};
    endfunction

    function automatic string tag_of(input int i);
        if (i == 0) return "R2 header0";
        else if (i == 1 || i == 38) return "R3 version";
        else if (i < 34) return "R4 data";
        else if (i < 38) return "R5 io";
        else return "R6 R7 R8 trailer1";
    endfunction

    task automatic new_inputs();
        evt = 8'($urandom);
        brd = 17'($urandom);
        bp  = 17'($urandom);
        for (int k = 0; k < 32; k++) src_v[k*16 +: 16] = 16'($urandom);
    endtask

    task automatic model_capture();
        if (m_cap) m_err[0] = 1'b1;
        m_cap = 1'b1;
        m_evt = evt; m_brd = brd; m_bp = bp; m_src = src_v;
    endtask

    task automatic do_capture();
        @(negedge clk);
        new_inputs();
        cap = 1'b1;
        model_capture();
        @(negedge clk);
        cap = 1'b0;
        new_inputs(); // scramble: stream must keep the snapshot (R4)
    endtask

    task automatic new_config();
        id_m = 1'($urandom);
        id_p = 2'($urandom % 3);
        id_s = 5'(2 + $urandom % 20);
        ver = 8'($urandom); rev = 8'($urandom);
        aver = 8'($urandom); arev = 8'($urandom);
    endtask

    task automatic readout(input bit with_cap, input int inj_idx, input bit inj_cap, input bit inj_xfer);
        logic start_cap;
        logic [3:0] late;
        late = '0;
        @(negedge clk);
        if (with_cap) begin
            new_inputs();
            cap = 1'b1;
            model_capture();
        end
        xfer = 1'b1;
        if (!m_cap) m_err[1] = 1'b1;
        start_cap = m_cap;
        @(negedge clk);
        cap = 1'b0; xfer = 1'b0;
        if (with_cap) new_inputs();
        for (int i = 0; i < NW; i++) begin
            chk(out_valid === 1'b1, "R1 valid during readout", 16'(out_valid), 16'd1);
            chk(out_last === (i == NW-1), "R1 last flag", 16'(out_last), 16'(i == NW-1));
            chk(out_word === exp_word(i, start_cap), tag_of(i), out_word, exp_word(i, start_cap));
            if (i == inj_idx) begin
                cap = inj_cap; xfer = inj_xfer;
                if (i < NW-1) m_err = m_err | {inj_xfer, inj_cap, 2'b00};
                else late = {inj_xfer, inj_cap, 2'b00};
            end
            @(negedge clk);
            cap = 1'b0; xfer = 1'b0;
        end
        chk(out_valid === 1'b0, "R1 valid drops after word 39", 16'(out_valid), 16'd0);
        chk(out_word === 16'd0, "R10 idle word zero", out_word, 16'd0);
        m_err = late;
        m_cap = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h1234_5eed));
        new_config();
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R10 reset valid", 16'(out_valid), 16'd0);
        chk(out_last === 1'b0, "R10 reset last", 16'(out_last), 16'd0);
        chk(out_word === 16'd0, "R10 reset word", out_word, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R10 idle after reset", 16'(out_valid), 16'd0);

        // R7 R10: transport straight after reset replays the zero snapshot with bit 11
        readout(0, -1, 0, 0);
        // R1 R2 R4: plain capture then readout
        do_capture();
        readout(0, -1, 0, 0);
        // R11: second transport without capture
        readout(0, -1, 0, 0);
        // R7 bit 10: double capture, newest kept
        do_capture();
        do_capture();
        readout(0, -1, 0, 0);
        // R9: capture and transport in the same cycle
        readout(1, -1, 0, 0);
        // R7 bit 12/13 mid-stream, and R8 late flag on word 39
        do_capture();
        readout(0, 5, 1, 1);
        do_capture();
        readout(0, NW-1, 1, 0);
        do_capture();
        readout(0, NW-1, 0, 1);
        readout(0, -1, 0, 0);

        // constrained random mix
        for (int it = 0; it < 60; it++) begin
            int ncap;
            int sel;
            new_config();
            ncap = $urandom % 3;
            for (int c = 0; c < ncap; c++) do_capture();
            repeat ($urandom % 3) @(negedge clk);
            sel = $urandom % 4;
            readout(($urandom % 5) == 0,
                    (sel == 0) ? -1 : (sel == 1) ? NW-1 : int'($urandom % NW),
                    1'($urandom), 1'($urandom));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule